// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under a mask that holds one bit per element. In compress mode, every element whose mask bit is set is packed, in ascending order, into the destination starting at position 0. The number of set bits is reported as the new packed vector length. In expand mode the movement is reversed: consecutive source elements, starting at position 0, are placed at the destination positions whose mask bit is set. Positions with a clear bit are never written, so they keep whatever the destination register already held.

A caller presents a mode, an active vector length and a mask together with a one-cycle start pulse. The unit then walks the active positions one per cycle. It reads the source register file through a port with one cycle of read latency and writes results through a destination write port. A running tally of the set bits seen so far gives the packed-side index for each move. When the walk ends, the unit raises a one-cycle done pulse together with the final tally, which is the packed length.

Top module: `cmx_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `src_rd_en`, `dst_we`, `done` and `count` are all 0.
- R2: With `mode` = 0 (compress), each source element i below the active length whose mask bit is set is written to destination index j, where j is the number of set mask bits below i. The writes come in ascending order of i.
- R3: In compress mode the number of destination writes equals the number of set mask bits within the active length. No other destination position is written.
- R4: `count` equals the number of set mask bits at positions below the active length and is valid in the cycle where `done` is high.
- R5: With `mode` = 1 (expand), each destination index i below the active length whose mask bit is set receives source element k, where k is the number of set mask bits below i. The writes come in ascending order of i.
- R6: In expand mode, destination positions whose mask bit is clear are not written.
- R7: The active length is `vl` clamped to MAXVL (64). Mask bits at or above it are ignored, and no read or write index reaches it.
- R8: `done` is high for exactly one cycle, in the cycle after the (L+1)-th rising edge that follows the edge on which `start` was taken, where L is the active length.
- R9: An all-zero mask or a zero length gives `count` = 0 and no destination writes, and `done` still follows R8.
- R10: In compress mode an all-ones mask gives an identity copy: destination i receives source i for every active i.
- R11: A `start` pulse that arrives while `busy` is high is ignored. It causes no extra writes and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| mode | input | 1 | 0 = compress, 1 = expand |
| vl | input | 7 | Requested vector length, clamped to 64 |
| mask | input | 64 | One bit per element |
| busy | output | 1 | Operation in progress |
| src_rd_en | output | 1 | Source read request |
| src_rd_idx | output | 6 | Source element index |
| src_rd_data | input | 64 | Source element, one cycle after the request |
| dst_we | output | 1 | Destination write strobe |
| dst_widx | output | 6 | Destination element index |
| dst_wdata | output | 64 | Destination element value |
| done | output | 1 | One-cycle completion pulse |
| count | output | 7 | Packed length (set bits within the active length) |

## Verification
The assertions check three properties on every cycle: every source read and destination write index stays below the active length, the done pulse never lasts two cycles, and the reported count never exceeds the active length. They also check that the running tally only grows during an operation. Only the bench scenarios can show that the right element lands at the right position for each mode. The same holds for the exact completion cycle, for the identity and empty-mask cases, for clamping of oversize lengths, and for a start arriving mid-operation being dropped.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  typedef enum logic {
    CMX_COMPRESS = 1'b0,
    CMX_EXPAND   = 1'b1
  } cmx_mode_e;
endpackage

// File: rtl/cmx_walker.sv
module cmx_walker
  import cmx_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int IDXW  = $clog2(MAXVL),
  parameter int LENW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LENW-1:0]  vl_in,
  input  logic [MAXVL-1:0] mask_in,
  input  cmx_mode_e        mode_in,
  output logic             active,
  output logic [IDXW-1:0]  idx,
  output logic             bit_now,
  output logic             last,
  output logic             empty_load,
  output logic [LENW-1:0]  len_q,
  output cmx_mode_e        mode_q
);
  localparam logic [LENW-1:0] MAXLEN = LENW'(MAXVL);

  logic [MAXVL-1:0] mask_q;
  logic [LENW-1:0]  len_eff;

  assign len_eff    = (vl_in > MAXLEN) ? MAXLEN : vl_in;
  assign empty_load = load && (len_eff == '0);
  assign bit_now    = mask_q[idx];
  assign last       = (({1'b0, idx} + LENW'(1)) == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      len_q  <= '0;
      mask_q <= '0;
      mode_q <= CMX_COMPRESS;
    end else if (load) begin
      len_q  <= len_eff;
      mask_q <= mask_in;
      mode_q <= mode_in;
      idx    <= '0;
      active <= (len_eff != '0);
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + IDXW'(1);
    end
  end

  assert_idx_below_len_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, idx} < len_q));
endmodule

// File: rtl/cmx_tally.sv
module cmx_tally #(
  parameter int LENW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            bump,
  output logic [LENW-1:0] tally
);
  always_ff @(posedge clk) begin
    if (rst || clear) tally <= '0;
    else if (bump)    tally <= tally + LENW'(1);
  end

  assert_tally_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear) |=> (tally >= $past(tally)));
endmodule

// File: rtl/cmx_unit.sv
module cmx_unit
  import cmx_pkg::*;
#(
  parameter int DW    = 64,
  parameter int MAXVL = 64,
  parameter int IDXW  = $clog2(MAXVL),
  parameter int LENW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [LENW-1:0]  vl,
  input  logic [MAXVL-1:0] mask,
  output logic             busy,
  output logic             src_rd_en,
  output logic [IDXW-1:0]  src_rd_idx,
  input  logic [DW-1:0]    src_rd_data,
  output logic             dst_we,
  output logic [IDXW-1:0]  dst_widx,
  output logic [DW-1:0]    dst_wdata,
  output logic             done,
  output logic [LENW-1:0]  count
);
  logic            accept;
  logic            w_active, w_bit, w_last, w_empty;
  logic [IDXW-1:0] w_idx;
  logic [LENW-1:0] w_len;
  cmx_mode_e       w_mode;
  logic [LENW-1:0] tally;
  logic            step_rd;
  logic [IDXW-1:0] wr_idx_next;
  logic            pend_q, tail_q;
  logic [IDXW-1:0] pend_idx_q;

  assign busy   = w_active | pend_q | tail_q;
  assign accept = start & ~busy;

  cmx_walker #(.MAXVL(MAXVL), .IDXW(IDXW), .LENW(LENW)) u_walker (
    .clk(clk), .rst(rst), .load(accept), .vl_in(vl), .mask_in(mask),
    .mode_in(cmx_mode_e'(mode)), .active(w_active), .idx(w_idx),
    .bit_now(w_bit), .last(w_last), .empty_load(w_empty),
    .len_q(w_len), .mode_q(w_mode)
  );

  assign step_rd = w_active & w_bit;

  cmx_tally #(.LENW(LENW)) u_tally (
    .clk(clk), .rst(rst), .clear(accept), .bump(step_rd), .tally(tally)
  );

  // packed-side index comes from the tally, sparse-side from the walker
  assign src_rd_en   = step_rd;
  assign src_rd_idx  = (w_mode == CMX_EXPAND) ? tally[IDXW-1:0] : w_idx;
  assign wr_idx_next = (w_mode == CMX_EXPAND) ? w_idx : tally[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      tail_q     <= 1'b0;
      dst_we     <= 1'b0;
      dst_widx   <= '0;
      dst_wdata  <= '0;
      done       <= 1'b0;
      count      <= '0;
    end else begin
      pend_q     <= step_rd;
      pend_idx_q <= wr_idx_next;
      tail_q     <= (w_active & w_last) | w_empty;
      dst_we     <= pend_q;
      if (pend_q) begin
        dst_widx  <= pend_idx_q;
        dst_wdata <= src_rd_data;
      end
      done <= tail_q;
      if (tail_q) count <= tally;
    end
  end

  assert_rd_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    src_rd_en |-> ({1'b0, src_rd_idx} < w_len));
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> ({1'b0, dst_widx} < w_len));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (count <= w_len));
endmodule

// File: tb/cmx_unit_bench.sv
`timescale 1ns/1ps
module cmx_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [6:0]  vl = '0;
  logic [63:0] mask = '0;
  logic        busy, src_rd_en, dst_we, done;
  logic [5:0]  src_rd_idx, dst_widx;
  logic [63:0] src_rd_data = '0;
  logic [63:0] dst_wdata;
  logic [6:0]  count;

  logic [63:0] src_mem [64];
  int          total = 0, fail = 0;
  int          exp_idx[$];
  logic [63:0] exp_dat[$];
  int          wcount = 0, range_bad = 0, extra = 0, cur_vl = 0, run_no = 0;
  string       main_tag = "R2", cur_ctx = "";

  always #2 clk = ~clk;

  cmx_unit u_cmx_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .vl(vl), .mask(mask),
    .busy(busy), .src_rd_en(src_rd_en), .src_rd_idx(src_rd_idx),
    .src_rd_data(src_rd_data), .dst_we(dst_we), .dst_widx(dst_widx),
    .dst_wdata(dst_wdata), .done(done), .count(count)
  );

  // source register file model: one cycle read latency
  always @(posedge clk) if (src_rd_en) src_rd_data <= src_mem[src_rd_idx];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every destination write
  always @(negedge clk) begin
    if (!rst && dst_we) begin
      wcount++;
      if (int'(dst_widx) >= cur_vl) range_bad++;
      if (exp_idx.size() == 0) extra++;
      else begin
        int ei;
        logic [63:0] ed;
        ei = exp_idx.pop_front();
        ed = exp_dat.pop_front();
        total++;
        if (ei != int'(dst_widx) || ed !== dst_wdata) begin
          fail++;
          $display("FAIL %s%s: write idx %0d data %h, expected idx %0d data %h",
                   main_tag, cur_ctx, dst_widx, dst_wdata, ei, ed);
        end
      end
    end
  end

  task automatic run(input logic md, input int vlen, input logic [63:0] msk,
                     input bit poke, input string ctx);
    int ev, j, edges, exp_n;
    string tn;
    run_no++;
    ev = (vlen > 64) ? 64 : vlen;
    cur_vl = ev;
    main_tag = md ? "R5" : "R2";
    tn = md ? "R6" : "R3";
    cur_ctx = ctx;
    for (int i = 0; i < 64; i++)
      src_mem[i] = {8'hC0, 8'(run_no), 16'(i), 32'(i * 32'h9E3779B1) ^ 32'(run_no)};
    j = 0;
    for (int i = 0; i < ev; i++) begin
      if (msk[i]) begin
        if (!md) begin exp_idx.push_back(j); exp_dat.push_back(src_mem[i]); end
        else     begin exp_idx.push_back(i); exp_dat.push_back(src_mem[j]); end
        j++;
      end
    end
    exp_n = j;
    wcount = 0; range_bad = 0; extra = 0;
    @(negedge clk);
    start = 1'b1; mode = md; vl = 7'(vlen); mask = msk;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (1) begin
      if (poke && edges == 2) begin
        start = 1'b1; mode = ~md; vl = 7'd64; mask = '1;
      end else start = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done || edges > 300) break;
    end
    start = 1'b0;
    chk(edges == ev + 1, {"R8 done timing", ctx}, edges, ev + 1);
    chk(int'(count) == exp_n, {"R4 count", ctx}, count, exp_n);
    @(posedge clk); @(negedge clk);
    chk(!done, {"R8 single done", ctx}, done, 0);
    chk(wcount == exp_n, {tn, " write total", ctx}, wcount, exp_n);
    chk(range_bad == 0, {"R7 index range", ctx}, range_bad, 0);
    chk(extra == 0 && exp_idx.size() == 0, {tn, " leftover/extra", ctx},
        extra + exp_idx.size(), 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(wcount == exp_n && !busy && !done, "R11 mid-run start ignored", wcount, exp_n);
    end
    exp_idx.delete(); exp_dat.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !src_rd_en && !dst_we && !done && count == 0, "R1 in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !src_rd_en && !dst_we && !done && count == 0, "R1 after reset", 1, 0);
    run(1'b0, 64, 64'hA5F0_0F5A_1234_8001, 1'b0, "");
    run(1'b0, 10, 64'hFFFF_FFFF_FFFF_FC35, 1'b0, " R7 mask above vl");
    run(1'b0, 64, '1, 1'b0, " R10 identity");
    run(1'b0, 64, '0, 1'b0, " R9 zero mask");
    run(1'b1, 64, 64'h8421_0F0F_F00F_3C3D, 1'b0, "");
    run(1'b1, 20, 64'hFFFF_FFFF_FFFA_AAAA, 1'b0, " R7 short expand");
    run(1'b1, 64, '0, 1'b0, " R9 zero mask expand");
    run(1'b0, 0, '1, 1'b0, " R9 zero length");
    run(1'b0, 16, 64'h0000_0000_0000_B6D3, 1'b1, " R11 poke");
    run(1'b1, 100, 64'hC000_0000_0000_0003, 1'b0, " R7 clamp");
    run(1'b0, 64, 64'h8000_0000_0000_0000, 1'b0, " top bit");
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule